// File: doc/BRIEF.md
# Accumulator Processor with Stack-Saved Interrupts

A small multi-cycle processor built around a single accumulator. Program and data share one memory, reached through one port with an address, a write-data bus, a read-data bus and separate read and write strobes. Each instruction is handled in fixed steps. In the fetch steps the program counter is copied into the address register and incremented, and a read is issued. The returned word is latched in the buffer register and then copied into the instruction register. The decode step splits that word into an opcode and an operand. An optional operand read follows, and then the execute step.

The memory is expected to be synchronous. A read strobed in one cycle returns its word on `mem_rdata_i` in the following cycle. A write is taken at the clock edge that ends the strobed cycle. The memory reads back 2^ADDR_W locations; with the default 8-bit address that is 256 words.

An interrupt request is looked at only at the end of an execute step. When one is taken, the return address, the accumulator and the status flags are written to a stack in memory that grows downward from the top address. Execution then continues at a fixed service address. A return instruction restores the three values in the opposite order.

Top module: `acc_cpu`

## Requirements
- R1: After reset the first access is a read of address 0. Every instruction begins with a read at the current program counter, and the program counter then advances by exactly one unless a branch or interrupt replaces it.
- R2: Read and write strobes are never active in the same cycle. Instruction fetches, operand reads, stores and stack traffic all use the one memory port.
- R3: An instruction word carries the opcode in bits 15:12, an immediate flag in bit 11 and an 8-bit operand in bits 7:0. For load, add, subtract and AND, a flag of 1 uses the operand zero-extended as the value, and a flag of 0 reads memory at the operand address. Opcodes: 0 load, 1 store, 2 add, 3 subtract, 4 AND, 5 jump, 6 jump-if-zero, 7 return-from-interrupt, 15 halt. Any other opcode does nothing.
- R4: Load, add, subtract and AND write their 16-bit result into the accumulator. They also set the zero flag (result equal to 0) and the negative flag (bit 15 of the result).
- R5: Store writes the accumulator to the operand address, ignoring the immediate flag.
- R6: Jump loads the program counter with the operand. Jump-if-zero does so only when the zero flag is set, and otherwise falls through.
- R7: Halt raises `halted_o` permanently. After that no memory access occurs and interrupt requests are ignored.
- R8: A request present at the end of an execute step, while unmasked, is taken. The return address is written to 0xFF, the accumulator to 0xFE, and the status word (bit 1 negative, bit 0 zero, other bits 0) to 0xFD. Fetching then resumes at 0xF0.
- R9: Return-from-interrupt reads 0xFD, 0xFE and 0xFF in that order. It restores the flags, then the accumulator, then the program counter, and the interrupted program resumes.
- R10: From the moment an interrupt is taken until its return completes, further requests are not taken. A request still held after the return is taken at the end of the next execute step.
- R11: Reset clears the program counter, accumulator and flags and sets the stack pointer to 0xFF.
- R12: Bits 10:8 of an instruction word have no effect on its behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request, level sensitive |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid the cycle after a read strobe |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| halted_o | output | 1 | Processor has executed halt |

## Verification
The case of interest is a request that arrives while the processor is still serving an earlier interrupt. The same request must then be taken right after the return restores context. The bench raises a request when instruction 9 is fetched and a second one when the second service instruction is fetched. It holds each request until the stacked return-address write appears on the port. A behavioural interpreter in the bench predicts every memory access in order, including the pushed status words and the second entry that begins one instruction after the return. Each strobe is compared against that prediction on the falling edge, and memory contents are compared once the processor halts.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h0;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'h3;
  localparam logic [OPC_W-1:0] OPC_AND   = 4'h4;
  localparam logic [OPC_W-1:0] OPC_JMP   = 4'h5;
  localparam logic [OPC_W-1:0] OPC_JZ    = 4'h6;
  localparam logic [OPC_W-1:0] OPC_RTI   = 4'h7;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND} alu_op_e;

  typedef enum logic [3:0] {
    ST_FETCH_ADDR, ST_FETCH_READ, ST_FETCH_LATCH, ST_DECODE,
    ST_MEM_READ, ST_MEM_LATCH, ST_EXECUTE, ST_PUSH,
    ST_POP_READ, ST_POP_LATCH, ST_HALT
  } cpu_state_e;
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         neg_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      default: res_o = b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
  assign neg_o  = res_o[W-1];
endmodule

// File: rtl/acc_cpu_stack.sv
module acc_cpu_stack #(
  parameter int ADDR_W    = 8,
  parameter int STACK_TOP = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] sp_next_o
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(STACK_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_o <= TOP;
    else if (push_i) sp_o <= sp_o - 1'b1;
    else if (pop_i)  sp_o <= sp_o + 1'b1;
  end

  assign sp_next_o = sp_o + 1'b1;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int VEC_ADDR  = 240,
  parameter int STACK_TOP = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              halted_o
);
  localparam int OPC_LSB = DATA_W - OPC_W;
  localparam int IMM_BIT = OPC_LSB - 1;
  localparam int EXT_W   = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] VEC = ADDR_W'(VEC_ADDR);

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic              imm;
    logic [ADDR_W-1:0] opnd;
  } instr_t;

  cpu_state_e        state;
  logic [ADDR_W-1:0] pc, mar, sp, sp_next;
  logic [DATA_W-1:0] mbr, acc, alu_res, alu_b;
  instr_t            cir, dec;
  logic [1:0]        sr;  // {neg, zero}
  logic [1:0]        ctx_idx;
  logic              masked, push, pop, alu_z, alu_n, is_alu, dec_alu;
  alu_op_e           alu_op;

  assign dec = '{opc: mbr[DATA_W-1:OPC_LSB], imm: mbr[IMM_BIT], opnd: mbr[ADDR_W-1:0]};
  assign dec_alu = dec.opc inside {OPC_LOAD, OPC_ADD, OPC_SUB, OPC_AND};
  assign is_alu  = cir.opc inside {OPC_LOAD, OPC_ADD, OPC_SUB, OPC_AND};
  assign alu_b   = cir.imm ? {{EXT_W{1'b0}}, cir.opnd} : mbr;

  always_comb begin
    unique case (cir.opc)
      OPC_ADD: alu_op = ALU_ADD;
      OPC_SUB: alu_op = ALU_SUB;
      OPC_AND: alu_op = ALU_AND;
      default: alu_op = ALU_PASS;
    endcase
  end

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .a_i(acc), .b_i(alu_b), .op_i(alu_op),
    .res_o(alu_res), .zero_o(alu_z), .neg_o(alu_n)
  );

  acc_cpu_stack #(.ADDR_W(ADDR_W), .STACK_TOP(STACK_TOP)) u_stack (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop),
    .sp_o(sp), .sp_next_o(sp_next)
  );

  always_comb begin
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_addr_o  = mar;
    mem_wdata_o = acc;
    push        = 1'b0;
    pop         = 1'b0;
    unique case (state)
      ST_FETCH_READ, ST_MEM_READ: mem_rd_o = 1'b1;
      ST_EXECUTE: mem_wr_o = (cir.opc == OPC_STORE);
      ST_PUSH: begin
        mem_wr_o   = 1'b1;
        mem_addr_o = sp;
        push       = 1'b1;
        unique case (ctx_idx)
          2'd0:    mem_wdata_o = {{EXT_W{1'b0}}, pc};
          2'd1:    mem_wdata_o = acc;
          default: mem_wdata_o = {{(DATA_W-2){1'b0}}, sr};
        endcase
      end
      ST_POP_READ: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = sp_next;
        pop        = 1'b1;
      end
      default: ;
    endcase
  end

  assign halted_o = (state == ST_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_FETCH_ADDR;
      pc      <= '0;
      mar     <= '0;
      mbr     <= '0;
      cir     <= '0;
      acc     <= '0;
      sr      <= '0;
      ctx_idx <= '0;
      masked  <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH_ADDR: begin
          mar   <= pc;
          pc    <= pc + 1'b1;
          state <= ST_FETCH_READ;
        end
        ST_FETCH_READ: state <= ST_FETCH_LATCH;
        ST_FETCH_LATCH: begin
          mbr   <= mem_rdata_i;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          cir <= dec;
          mar <= dec.opnd;
          if (dec.opc == OPC_HALT) state <= ST_HALT;
          else if (dec.opc == OPC_RTI) begin
            ctx_idx <= '0;
            state   <= ST_POP_READ;
          end else if (dec_alu && !dec.imm) state <= ST_MEM_READ;
          else state <= ST_EXECUTE;
        end
        ST_MEM_READ: state <= ST_MEM_LATCH;
        ST_MEM_LATCH: begin
          mbr   <= mem_rdata_i;
          state <= ST_EXECUTE;
        end
        ST_EXECUTE: begin
          if (is_alu) begin
            acc <= alu_res;
            sr  <= {alu_n, alu_z};
          end
          if (cir.opc == OPC_JMP || (cir.opc == OPC_JZ && sr[0])) pc <= cir.opnd;
          if (irq_i && !masked) begin
            masked  <= 1'b1;
            ctx_idx <= '0;
            state   <= ST_PUSH;
          end else state <= ST_FETCH_ADDR;
        end
        ST_PUSH: begin
          ctx_idx <= ctx_idx + 2'd1;
          if (ctx_idx == 2'd2) begin
            pc    <= VEC;
            state <= ST_FETCH_ADDR;
          end
        end
        ST_POP_READ: state <= ST_POP_LATCH;
        ST_POP_LATCH: begin
          ctx_idx <= ctx_idx + 2'd1;
          unique case (ctx_idx)
            2'd0: sr  <= mem_rdata_i[1:0];
            2'd1: acc <= mem_rdata_i;
            default: pc <= mem_rdata_i[ADDR_W-1:0];
          endcase
          if (ctx_idx == 2'd2) begin
            masked <= 1'b0;
            state  <= ST_FETCH_ADDR;
          end else state <= ST_POP_READ;
        end
        default: state <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STACK_TOP = 255
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic              halted_i,
  input cpu_state_e        state_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] sp_i,
  input logic              masked_i
);
  assert_rd_wr_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));

  assert_halt_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> (!rd_i && !wr_i));

  assert_halt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);

  assert_pc_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH_ADDR) |=> (pc_i == $past(pc_i) + 1'b1));

  assert_sp_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sp_i) <= STACK_TOP) && (int'(sp_i) >= STACK_TOP - 3));

  assert_mask_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(masked_i) |-> (state_i == ST_PUSH));

  assert_no_nest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_i && state_i == ST_EXECUTE) |=> (state_i != ST_PUSH));
endmodule

bind acc_cpu acc_cpu_checker #(.ADDR_W(ADDR_W), .STACK_TOP(STACK_TOP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(mem_rd_o), .wr_i(mem_wr_o),
  .halted_i(halted_o), .state_i(state), .pc_i(pc), .sp_i(sp), .masked_i(masked)
);

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0, rst_n = 1'b0, irq = 1'b0;
  logic [7:0]  addr;
  logic [15:0] wdata, rdata;
  logic        rd, wr, halted;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_rd_o(rd),
    .mem_wr_o(wr), .halted_o(halted)
  );

  logic [15:0] mem_dut [256];
  logic [15:0] mem_ref [256];

  always @(posedge clk) begin
    if (wr) mem_dut[addr] <= wdata;
    if (rd) rdata <= mem_dut[addr];
  end

  typedef struct { bit wr; logic [7:0] addr; logic [15:0] data; string tag; } acc_t;
  acc_t exp_q[$];

  int checks = 0, errors = 0;
  logic [7:0]  m_pc = 8'h00, m_sp = 8'hFF;
  logic [15:0] m_acc = '0;
  logic        m_z = 1'b0, m_n = 1'b0, m_masked = 1'b0, m_halted = 1'b0, m_pending = 1'b0;
  bit          trig1 = 0, trig2 = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int imm, input int opnd);
    return 16'((op << 12) | (imm << 11) | opnd);
  endfunction

  task automatic expect_acc(input bit w, input logic [7:0] a, input logic [15:0] d, input string t);
    acc_t e;
    e.wr = w; e.addr = a; e.data = d; e.tag = t;
    exp_q.push_back(e);
  endtask

  // instruction-level interpreter producing the expected port traffic
  task automatic model_step();
    logic [15:0] ins, b, ret;
    logic [3:0]  op;
    logic [7:0]  opnd;
    if (m_halted) return;
    ins = mem_ref[m_pc];
    expect_acc(0, m_pc, '0, "R1");
    m_pc = m_pc + 8'd1;
    op = ins[15:12]; opnd = ins[7:0];
    case (op)
      4'h0, 4'h2, 4'h3, 4'h4: begin
        if (ins[11]) b = {8'h00, opnd};
        else begin
          expect_acc(0, opnd, '0, "R3");
          b = mem_ref[opnd];
        end
        case (op)
          4'h0: m_acc = b;
          4'h2: m_acc = m_acc + b;
          4'h3: m_acc = m_acc - b;
          default: m_acc = m_acc & b;
        endcase
        m_z = (m_acc == 0); m_n = m_acc[15];
      end
      4'h1: begin
        expect_acc(1, opnd, m_acc, "R5");
        mem_ref[opnd] = m_acc;
      end
      4'h5: m_pc = opnd;
      4'h6: if (m_z) m_pc = opnd;
      4'h7: begin
        m_sp = m_sp + 8'd1; expect_acc(0, m_sp, '0, "R9");
        {m_n, m_z} = mem_ref[m_sp][1:0];
        m_sp = m_sp + 8'd1; expect_acc(0, m_sp, '0, "R9");
        m_acc = mem_ref[m_sp];
        m_sp = m_sp + 8'd1; expect_acc(0, m_sp, '0, "R9");
        m_pc = mem_ref[m_sp][7:0];
        m_masked = 1'b0;
        return;
      end
      4'hF: begin m_halted = 1'b1; return; end
      default: ;
    endcase
    if (m_pending && !m_masked) begin
      m_pending = 1'b0; m_masked = 1'b1;
      ret = {8'h00, m_pc};
      expect_acc(1, m_sp, ret, "R8"); mem_ref[m_sp] = ret; m_sp = m_sp - 8'd1;
      expect_acc(1, m_sp, m_acc, "R8"); mem_ref[m_sp] = m_acc; m_sp = m_sp - 8'd1;
      expect_acc(1, m_sp, {14'd0, m_n, m_z}, "R8"); mem_ref[m_sp] = {14'd0, m_n, m_z};
      m_sp = m_sp - 8'd1;
      m_pc = 8'hF0;
    end
  endtask

  // per-cycle comparison of port traffic against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd && wr) check(0, "R2", "rd and wr together", {rd, wr}, 2'b10);
      if (rd || wr) begin
        if (rd && addr == 8'd9 && !trig1) begin trig1 = 1; irq <= 1'b1; m_pending = 1'b1; end
        if (rd && addr == 8'hF1 && !trig2) begin trig2 = 1; irq <= 1'b1; m_pending = 1'b1; end
        if (exp_q.size() == 0) model_step();
        if (exp_q.size() == 0)
          check(0, "R7", "unexpected access", {23'd0, wr, addr}, 32'd0);
        else begin
          acc_t e;
          e = exp_q.pop_front();
          check(wr == e.wr && addr == e.addr, e.tag, "access kind/address",
                {23'd0, wr, addr}, {23'd0, e.wr, e.addr});
          if (wr) check(wdata == e.data, e.tag, "write data", wdata, e.data);
        end
        if (wr && addr == 8'hFF) irq <= 1'b0;
      end
      if (halted && !(m_halted && exp_q.size() == 0))
        check(0, "R7", "halted early", halted, 0);
    end
  end

  function automatic string tag_of(input int a);
    case (a)
      8'h90: return "R11";
      8'h91: return "R6";
      8'h92: return "R12";
      8'h93: return "R10";
      default: return "R4";
    endcase
  endfunction

  initial begin
    int cyc;
    for (int i = 0; i < 256; i++) begin mem_dut[i] = '0; mem_ref[i] = '0; end
    mem_ref[0]  = enc(1, 0, 8'h90);           // store reset ACC
    mem_ref[1]  = enc(0, 0, 8'h80);           // load mem 5
    mem_ref[2]  = enc(2, 0, 8'h81);           // add mem 3
    mem_ref[3]  = enc(3, 1, 8);               // sub #8 -> zero
    mem_ref[4]  = enc(6, 0, 6);               // jz taken
    mem_ref[5]  = enc(15, 0, 0);
    mem_ref[6]  = enc(1, 0, 8'h91);
    mem_ref[7]  = enc(0, 1, 8'h0F) | 16'h0700; // reserved bits set
    mem_ref[8]  = enc(4, 0, 8'h82);           // and mem
    mem_ref[9]  = enc(3, 1, 6);               // -> FFFF, negative; first request
    mem_ref[10] = enc(6, 0, 5);               // jz not taken
    mem_ref[11] = enc(1, 0, 8'h92);
    mem_ref[12] = enc(5, 0, 14);
    mem_ref[13] = enc(15, 0, 0);
    mem_ref[14] = 16'h8000;                   // unused opcode
    mem_ref[15] = enc(0, 0, 8'h92);
    mem_ref[16] = enc(2, 1, 1);
    mem_ref[17] = enc(1, 0, 8'h94);
    mem_ref[18] = enc(15, 0, 0);
    mem_ref[8'h80] = 16'h0005;
    mem_ref[8'h81] = 16'h0003;
    mem_ref[8'h82] = 16'h00F5;
    mem_ref[8'hF0] = enc(0, 1, 0);            // service routine
    mem_ref[8'hF1] = enc(1, 0, 8'h93);        // second request raised here
    mem_ref[8'hF2] = enc(7, 0, 0);
    for (int i = 0; i < 256; i++) mem_dut[i] = mem_ref[i];

    repeat (3) @(negedge clk);
    check(!halted && !rd && !wr, "R11", "outputs in reset", {halted, rd, wr}, 0);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < WATCHDOG) begin @(negedge clk); cyc++; end
    if (!halted) check(0, "R7", "watchdog expired", cyc, WATCHDOG);
    else begin
      check(exp_q.size() == 0, "R7", "pending accesses at halt", exp_q.size(), 0);
      irq = 1'b1;
      repeat (20) @(negedge clk);
      check(halted && !rd && !wr, "R7", "halt with request", {halted, rd, wr}, 3'b100);
      irq = 1'b0;
      for (int a = 8'h90; a <= 8'h94; a++)
        check(mem_dut[a] === mem_ref[a], tag_of(a), "stored word", mem_dut[a], mem_ref[a]);
      for (int a = 8'hFD; a <= 8'hFF; a++)
        check(mem_dut[a] === mem_ref[a], "R8", "stack word", mem_dut[a], mem_ref[a]);
      check(mem_ref[8'h92] == 16'hFFFF && mem_ref[8'h94] == 16'h0000, "R9",
            "model sanity after return", mem_ref[8'h92], 16'hFFFF);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule